// File: doc/BRIEF.md
# SRAM Acknowledge and Strobe Generator

This block sits between a 16-bit asynchronous-bus processor and a bank of static RAM. It watches the address strobe, the two byte-lane data strobes, the read/write line and the word address. When a cycle targets the SRAM window, it drives the RAM's chip select and output enable, or the byte-lane write enables. It then counts cycles of a fast local clock until the RAM's access time has passed. Only after that count does it assert the active-low transfer acknowledge.

Static RAM gives no ready signal, so the acknowledge delay comes entirely from that count. The count length is a parameter and can include a safety cycle for glue-logic delay. The bus control lines are asynchronous to the local clock, so they pass through a two-stage synchronizer before the controller acts on them. The address is assumed stable while the address strobe is low, and it is decoded directly.

The controller is a four-state machine:
- `ST_IDLE` waits for a cycle to start.
- `ST_COUNT` drives the RAM and counts the wait.
- `ST_ACK` holds the acknowledge low.
- `ST_SKIP` waits out a cycle that targets another region.

It has these transitions:
- `ST_IDLE` to `ST_COUNT` when a cycle starts and the address hits the window.
- `ST_IDLE` to `ST_SKIP` when a cycle starts and the address misses the window.
- `ST_COUNT` to `ST_ACK` when the count completes.
- `ST_COUNT`, `ST_ACK` or `ST_SKIP` to `ST_IDLE` when the synchronized address strobe is seen high.

Top module: `sram_ack_gen`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, every output (`sram_cs_n`, `sram_oe_n`, `sram_we_hi_n`, `sram_we_lo_n`, `dtack_n`) is high.
- R2: A cycle starts only when the synchronized `as_n` is low and at least one of `uds_n`/`lds_n` is low. With the address strobe low and both data strobes high, all outputs stay high.
- R3: The SRAM window is selected when address bits `addr[22:19]` (byte address bits 23..20) are all zero, which is the first 1 MiB. A cycle outside the window never asserts `sram_cs_n` or `dtack_n`.
- R4: If the start condition is applied before clock edge k, `dtack_n` goes low after edge k+2+WAIT_CYC. That is two synchronizer edges, one decision edge and WAIT_CYC counting edges. The default WAIT_CYC is 3.
- R5: `sram_cs_n` is low from the decision edge until release, covering the whole count and the acknowledge.
- R6: On a read (`rw`=1), `sram_oe_n` is low exactly while `sram_cs_n` is low, and both write enables stay high.
- R7: On a write (`rw`=0), `sram_we_hi_n` follows the synchronized `uds_n` and `sram_we_lo_n` follows the synchronized `lds_n`, only while `sram_cs_n` is low. `sram_oe_n` stays high.
- R8: When `as_n` rises before edge m, all outputs are high after edge m+2. This also applies when the rise comes during the count, which aborts the cycle with no acknowledge.
- R9: A following cycle restarts the count from zero and shows the same acknowledge latency as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| uds_n | input | 1 | Upper byte data strobe, active low |
| lds_n | input | 1 | Lower byte data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W (23) | Word address, bit i is byte address bit i+1 |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_hi_n | output | 1 | Upper byte write enable, active low |
| sram_we_lo_n | output | 1 | Lower byte write enable, active low |
| dtack_n | output | 1 | Transfer acknowledge, active low |

## Verification
The bench drives several kinds of bus cycle:
- Reads with both lanes and with a single lane, which separate output-enable timing from byte-lane handling.
- Writes to the upper lane only, the lower lane only and both lanes, which show whether each write enable follows its own strobe.
- A cycle outside the window and an address strobe with no data strobe, which show that the decode and the start condition gate the count.
- An early release that aborts the count, and back-to-back cycles, which show that the counter is cleared between cycles.

The acknowledge latency and the release latency are also measured directly in clock edges.

// File: rtl/sram_ack_pkg.sv
package sram_ack_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_ACK   = 2'd2,
        ST_SKIP  = 2'd3
    } ack_state_t;

    typedef struct packed {
        logic as_n;
        logic uds_n;
        logic lds_n;
        logic rw;
    } bus_ctl_t;

    localparam int CTL_W = $bits(bus_ctl_t);

endpackage

// File: rtl/sram_ack_sync.sv
module sram_ack_sync #(
    parameter int          WIDTH     = 4,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= RESET_VAL;
                    else        stg[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= RESET_VAL;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/sram_ack_decode.sv
module sram_ack_decode #(
    parameter int                ADDR_W = 23,
    parameter logic [ADDR_W-1:0] MASK   = 23'h78_0000,
    parameter logic [ADDR_W-1:0] BASE   = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    always_comb begin
        hit = ((addr & MASK) == (BASE & MASK));
    end

endmodule

// File: rtl/sram_ack_counter.sv
module sram_ack_counter #(
    parameter int WAIT_CYC = 3,
    parameter int CNT_W    = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    output logic             done,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);

    always_comb begin
        done = (cnt >= LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (clear)         cnt <= '0;
        else if (run && !done)  cnt <= cnt + CNT_W'(1);
    end

endmodule

// File: rtl/sram_ack_gen.sv
module sram_ack_gen
    import sram_ack_pkg::*;
#(
    parameter int                ADDR_W      = 23,
    parameter int                WAIT_CYC    = 3,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] WIN_MASK    = 23'h78_0000,
    parameter logic [ADDR_W-1:0] WIN_BASE    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic              uds_n,
    input  logic              lds_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    output logic              sram_cs_n,
    output logic              sram_oe_n,
    output logic              sram_we_hi_n,
    output logic              sram_we_lo_n,
    output logic              dtack_n
);

    localparam int CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);

    bus_ctl_t   ctl_raw;
    bus_ctl_t   ctl_s;
    logic       as_sn;
    logic       hit;
    logic       start;
    logic       cnt_done;
    logic       cnt_clear;
    logic       cnt_run;
    logic [CNT_W-1:0] cnt;
    ack_state_t state_q;
    ack_state_t state_d;
    logic       active;

    assign ctl_raw = '{as_n: as_n, uds_n: uds_n, lds_n: lds_n, rw: rw};

    sram_ack_sync #(
        .WIDTH    (CTL_W),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(4'b1111)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (ctl_raw),
        .q    (ctl_s)
    );

    assign as_sn = ctl_s.as_n;

    sram_ack_decode #(
        .ADDR_W(ADDR_W),
        .MASK  (WIN_MASK),
        .BASE  (WIN_BASE)
    ) u_dec (
        .addr(addr),
        .hit (hit)
    );

    sram_ack_counter #(
        .WAIT_CYC(WAIT_CYC),
        .CNT_W   (CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(cnt_clear),
        .run  (cnt_run),
        .done (cnt_done),
        .cnt  (cnt)
    );

    assign cnt_run   = (state_q == ST_COUNT);
    assign cnt_clear = (state_q != ST_COUNT);
    assign start     = !ctl_s.as_n && (!ctl_s.uds_n || !ctl_s.lds_n);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = hit ? ST_COUNT : ST_SKIP;
            end
            ST_COUNT: begin
                if (ctl_s.as_n)    state_d = ST_IDLE;
                else if (cnt_done) state_d = ST_ACK;
            end
            ST_ACK: begin
                if (ctl_s.as_n) state_d = ST_IDLE;
            end
            ST_SKIP: begin
                if (ctl_s.as_n) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        active       = (state_q == ST_COUNT) || (state_q == ST_ACK);
        sram_cs_n    = !active;
        sram_oe_n    = !(active && ctl_s.rw);
        sram_we_hi_n = !(active && !ctl_s.rw && !ctl_s.uds_n);
        sram_we_lo_n = !(active && !ctl_s.rw && !ctl_s.lds_n);
        dtack_n      = !(state_q == ST_ACK);
    end

endmodule

// File: rtl/sram_ack_gen_chk.sv
module sram_ack_gen_chk #(
    parameter int WAIT_CYC = 3,
    parameter int CNT_W    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             as_sn,
    input logic             hit,
    input logic [CNT_W-1:0] cnt,
    input logic             sram_cs_n,
    input logic             sram_oe_n,
    input logic             sram_we_hi_n,
    input logic             sram_we_lo_n,
    input logic             dtack_n
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        as_sn |=> (dtack_n && sram_cs_n));

    // R5
    ack_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_n |-> !sram_cs_n);

    // R6
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (sram_we_hi_n && sram_we_lo_n));

    // R3
    window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_cs_n) |-> $past(hit));

    // R4
    ack_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> $past(!sram_cs_n));

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R7
    we_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_hi_n || !sram_we_lo_n) |-> !sram_cs_n);

endmodule

bind sram_ack_gen sram_ack_gen_chk #(
    .WAIT_CYC(WAIT_CYC),
    .CNT_W   (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .as_sn       (as_sn),
    .hit         (hit),
    .cnt         (cnt),
    .sram_cs_n   (sram_cs_n),
    .sram_oe_n   (sram_oe_n),
    .sram_we_hi_n(sram_we_hi_n),
    .sram_we_lo_n(sram_we_lo_n),
    .dtack_n     (dtack_n)
);

// File: tb/sram_ack_gen_bench.sv
module sram_ack_gen_bench;

    localparam int WAIT_CYC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_n = 1'b1;
    logic        uds_n = 1'b1;
    logic        lds_n = 1'b1;
    logic        rw = 1'b1;
    logic [22:0] addr = '0;
    logic        sram_cs_n, sram_oe_n, sram_we_hi_n, sram_we_lo_n, dtack_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sram_ack_gen u_sram_ack_gen (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
        .rw(rw), .addr(addr), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
        .sram_we_hi_n(sram_we_hi_n), .sram_we_lo_n(sram_we_lo_n), .dtack_n(dtack_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Reference model: raw control history, phase 0 idle, 1 counting, 2 ack, 3 skip
    logic [3:0] hist[$];
    int   ph = 0;
    int   elapsed = 0;
    logic [4:0] exp_o = 5'b11111;

    always @(posedge clk) begin
        logic [3:0] prev_s;
        logic [3:0] now_s;
        bit         act;
        if (!rst_n) begin
            hist = {4'hF, 4'hF, 4'hF};
            ph = 0;
            elapsed = 0;
            exp_o = 5'b11111;
        end else begin
            hist.push_front({as_n, uds_n, lds_n, rw});
            void'(hist.pop_back());
            prev_s = hist[2];
            now_s  = hist[1];
            case (ph)
                0: if (!prev_s[3] && (!prev_s[2] || !prev_s[1])) begin
                       ph = (addr[22:19] == 4'd0) ? 1 : 3;
                       elapsed = 0;
                   end
                1: if (prev_s[3]) ph = 0;
                   else begin
                       elapsed++;
                       if (elapsed >= WAIT_CYC) ph = 2;
                   end
                default: if (prev_s[3]) ph = 0;
            endcase
            act = (ph == 1) || (ph == 2);
            exp_o[4] = !act;
            exp_o[3] = !(act && now_s[0]);
            exp_o[2] = !(act && !now_s[0] && !now_s[2]);
            exp_o[1] = !(act && !now_s[0] && !now_s[1]);
            exp_o[0] = !(ph == 2);
        end
    end

    // Per-clock comparison (R4 R5 R6 R7 R8), away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [4:0] got;
            got = {sram_cs_n, sram_oe_n, sram_we_hi_n, sram_we_lo_n, dtack_n};
            chk(got == exp_o, "R5_R6_R7_R4_model", int'(got), int'(exp_o));
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_cycle(input logic [22:0] a, input logic r, input logic u,
                             input logic l, input int hold);
        @(negedge clk);
        addr = a; rw = r;
        @(negedge clk);
        as_n = 1'b0;
        @(negedge clk);
        uds_n = u; lds_n = l;
        idle(hold);
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
        idle(4);
        rw = 1'b1;
    endtask

    task automatic measure_ack(input string req);
        int n;
        @(negedge clk);
        addr = 23'h00_1234; rw = 1'b1;
        @(negedge clk);
        as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            n++;
            if (!dtack_n) break;
        end
        chk(n == 3 + WAIT_CYC, req, n, 3 + WAIT_CYC);
        // R8 release latency
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            n++;
            if (dtack_n && sram_cs_n && sram_oe_n) break;
        end
        chk(n == 3, "R8_release", n, 3);
        idle(2);
    endtask

    initial begin
        idle(3);
        // R1 reset state
        chk({sram_cs_n, sram_oe_n, sram_we_hi_n, sram_we_lo_n, dtack_n} == 5'b11111,
            "R1_in_reset", int'({sram_cs_n, sram_oe_n, sram_we_hi_n, sram_we_lo_n, dtack_n}), 31);
        rst_n = 1'b1;
        @(negedge clk);
        chk({sram_cs_n, sram_oe_n, sram_we_hi_n, sram_we_lo_n, dtack_n} == 5'b11111,
            "R1_after_reset", int'({sram_cs_n, sram_oe_n, sram_we_hi_n, sram_we_lo_n, dtack_n}), 31);

        // R4 latency, then R9 same latency on the next cycle
        measure_ack("R4_latency");
        measure_ack("R9_repeat_latency");

        // R6 reads: both lanes and lower only
        bus_cycle(23'h00_0100, 1'b1, 1'b0, 1'b0, 10);
        bus_cycle(23'h07_ffff, 1'b1, 1'b1, 1'b0, 10);

        // R7 writes: upper only, with a mid-cycle lane check
        @(negedge clk);
        addr = 23'h00_0200; rw = 1'b0;
        @(negedge clk);
        as_n = 1'b0; uds_n = 1'b0;
        idle(5);
        chk(!sram_we_hi_n && sram_we_lo_n && sram_oe_n, "R7_upper_lane",
            int'({sram_we_hi_n, sram_we_lo_n, sram_oe_n}), 3);
        as_n = 1'b1; uds_n = 1'b1;
        idle(4);
        rw = 1'b1;
        bus_cycle(23'h00_0300, 1'b0, 1'b1, 1'b0, 10);
        bus_cycle(23'h00_0400, 1'b0, 1'b0, 1'b0, 10);

        // R3 outside the window
        @(negedge clk);
        addr = 23'h40_0000; rw = 1'b1;
        @(negedge clk);
        as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
        idle(10);
        chk(dtack_n && sram_cs_n, "R3_outside", int'({dtack_n, sram_cs_n}), 3);
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
        idle(4);

        // R2 address strobe alone
        @(negedge clk);
        addr = 23'h00_0010;
        as_n = 1'b0;
        idle(10);
        chk(dtack_n && sram_cs_n && sram_oe_n, "R2_no_data_strobe",
            int'({dtack_n, sram_cs_n, sram_oe_n}), 7);
        as_n = 1'b1;
        idle(4);

        // R8 abort during the count
        bus_cycle(23'h00_0500, 1'b1, 1'b0, 1'b0, 1);
        chk(dtack_n && sram_cs_n, "R8_abort_idle", int'({dtack_n, sram_cs_n}), 3);

        // R9 back-to-back with minimum gap
        bus_cycle(23'h00_0600, 1'b0, 1'b0, 1'b1, 8);
        bus_cycle(23'h00_0700, 1'b1, 1'b0, 1'b0, 8);
        measure_ack("R9_after_traffic");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule